// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Pending States

This block arbitrates a set of interrupt request lines for a single processor. Each line is set up as level-sensitive or pulse-sensitive, can be masked, and carries a programmable priority. Every line holds one of four states: idle, pending, active, or active with another event pending. The controller selects the most urgent enabled pending line. It raises a request to the processor only when that line is strictly more urgent than the handler that is running.

The processor enters a handler with an acknowledge strobe and leaves it with an end-of-interrupt strobe. A stack records the priority of every handler that has been entered, so the running level drops back to the level below when a nested handler returns. Software can also force or drop a pending event on any line. Inputs are synchronized with two flops. Pulse lines trigger on a rising edge after the synchronizer; level lines are sampled as levels.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset no line is pending or active, `cpu_req` is 0, `nest_depth` is 0, `run_valid` is 0 and `eoi_err` is 0.
- R2: A line whose `cfg_enable` bit is 0 never raises `cpu_req`. Its pending state is still recorded and shows on `pending`.
- R3: Among the enabled pending lines the one with the smallest `cfg_prio` value is presented on `req_id`/`req_prio`. A value of 0 is the most urgent. On a tie the lowest line index wins.
- R4: `cpu_req` is 1 only if a candidate exists and either no handler is running or the candidate's priority value is strictly smaller than `run_prio`. Equal priority waits.
- R5: An `ack` while `cpu_req` is 1 clears that line's pending bit, sets its active bit, and increments `nest_depth`. `run_prio` becomes the acknowledged line's priority. An `ack` while `cpu_req` is 0 has no effect.
- R6: For a level line (`cfg_level` bit = 1), `eoi` samples the input. The line becomes pending if the input is still high and idle otherwise. While it is active, its input does not set pending.
- R7: For a pulse line (`cfg_level` bit = 0), a rising edge while the line is active makes it active and pending. After `eoi` it is pending and is presented again.
- R8: `sw_set_pend` makes a line pending. `sw_clr_pend` clears it. A level line that is not active and whose input is still high becomes pending again on the next sample.
- R9: `eoi` retires the most recently entered handler. It decrements `nest_depth`, and `run_prio` returns to the priority of the handler below.
- R10: An `eoi` with no handler running changes no line state. It sets `eoi_err`, which stays 1 until reset.
- R11: When `ack` and `eoi` arrive in the same cycle, the end-of-interrupt is carried out and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Raw request lines |
| cfg_level | input | N | 1 = level-sensitive, 0 = pulse (rising edge) |
| cfg_enable | input | N | 1 = line may be forwarded |
| cfg_prio | input | N*PW | Priority per line, line i at bits [i*PW +: PW], smaller is more urgent |
| sw_set_pend | input | N | Software set-pending strobe per line |
| sw_clr_pend | input | N | Software clear-pending strobe per line |
| ack | input | 1 | Handler entry strobe for the presented line |
| eoi | input | 1 | Handler return strobe |
| cpu_req | output | 1 | Interrupt request to the processor |
| req_id | output | IDW | Index of the presented line |
| req_prio | output | PW | Priority of the presented line |
| run_valid | output | 1 | A handler is running |
| run_prio | output | PW | Priority of the running handler |
| nest_depth | output | DW | Number of nested active handlers |
| pending | output | N | Pending bit per line |
| active | output | N | Active bit per line |
| eoi_err | output | 1 | Sticky flag: return strobe with nothing active |

## Verification
The acknowledge and end-of-interrupt strobes can fall in the same cycle. The bench provokes this while a handler is running and a more urgent line is waiting. It then judges that the depth fell by one, that the retired line is no longer active and that the waiting line is still pending and not yet entered. A second overlap is a new event on a line that is already active. Such an event must neither be lost nor enter the handler twice, so the bench checks the active-and-pending state and the re-presentation after return against its own model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Per-line state; bit 0 = pending, bit 1 = active
  typedef enum logic [1:0] {
    LS_IDLE    = 2'b00,
    LS_PEND    = 2'b01,
    LS_ACT     = 2'b10,
    LS_ACTPEND = 2'b11
  } line_st_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic is_level,
  input  logic lvl,
  input  logic rise,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic take,
  input  logic ret,
  output logic pend,
  output logic act
);
  line_st_e st, st_n;
  logic     pend_set, pend_n, act_n;

  assign pend = st[0];
  assign act  = st[1];

  always_comb begin
    // level lines are sampled while idle/pending and again at return
    if (is_level) pend_set = sw_set | (lvl & ((~act & ~take) | ret));
    else          pend_set = sw_set | rise;
    pend_n = sw_clr ? 1'b0 : ((pend & ~take) | pend_set);
    act_n  = ret ? 1'b0 : (take ? 1'b1 : act);
    st_n   = line_st_e'({act_n, pend_n});
  end

  always_ff @(posedge clk) begin
    if (rst) st <= LS_IDLE;
    else     st <= st_n;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N   = 8,
  parameter int PW  = 3,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IDW-1:0]  sel_id,
  output logic [PW-1:0]   sel_prio
);
  always_comb begin
    found    = 1'b0;
    sel_id   = '0;
    sel_prio = '0;
    // scan downward so that equal priority settles on the lowest index
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[i*PW +: PW] <= sel_prio)) begin
        found    = 1'b1;
        sel_id   = IDW'(i);
        sel_prio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
  parameter int N   = 8,
  parameter int PW  = 3,
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int DW  = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic [PW-1:0]  push_prio,
  input  logic           pop,
  output logic [DW-1:0]  depth,
  output logic           top_valid,
  output logic [IDW-1:0] top_id,
  output logic [PW-1:0]  top_prio
);
  logic [IDW-1:0] stk_id [N];
  logic [PW-1:0]  stk_pr [N];
  logic [IDW-1:0] wr_ptr, rd_ptr;

  assign wr_ptr    = IDW'(depth);
  assign rd_ptr    = IDW'(depth - 1'b1);
  assign top_valid = (depth != '0);
  assign top_id    = stk_id[rd_ptr];
  assign top_prio  = stk_pr[rd_ptr];

  // storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (push) begin
      stk_id[wr_ptr] <= push_id;
      stk_pr[wr_ptr] <= push_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      depth <= '0;
    else if (pop && top_valid)    depth <= depth - 1'b1;
    else if (push && depth != DW'(N)) depth <= depth + 1'b1;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N   = 8,
  parameter int PW  = 3,
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int DW  = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    irq_in,
  input  logic [N-1:0]    cfg_level,
  input  logic [N-1:0]    cfg_enable,
  input  logic [N*PW-1:0] cfg_prio,
  input  logic [N-1:0]    sw_set_pend,
  input  logic [N-1:0]    sw_clr_pend,
  input  logic            ack,
  input  logic            eoi,
  output logic            cpu_req,
  output logic [IDW-1:0]  req_id,
  output logic [PW-1:0]   req_prio,
  output logic            run_valid,
  output logic [PW-1:0]   run_prio,
  output logic [DW-1:0]   nest_depth,
  output logic [N-1:0]    pending,
  output logic [N-1:0]    active,
  output logic            eoi_err
);
  logic [N-1:0]   lvl_s, rise_s, take_vec, ret_vec;
  logic           found, ack_do, eoi_do;
  logic [IDW-1:0] top_id;

  irq_sync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .din(irq_in), .lvl(lvl_s), .rise(rise_s)
  );

  for (genvar g = 0; g < N; g++) begin : g_line
    irq_line u_line (
      .clk(clk), .rst(rst), .is_level(cfg_level[g]),
      .lvl(lvl_s[g]), .rise(rise_s[g]),
      .sw_set(sw_set_pend[g]), .sw_clr(sw_clr_pend[g]),
      .take(take_vec[g]), .ret(ret_vec[g]),
      .pend(pending[g]), .act(active[g])
    );
  end

  irq_pick #(.N(N), .PW(PW)) u_pick (
    .cand(pending & cfg_enable), .prio(cfg_prio),
    .found(found), .sel_id(req_id), .sel_prio(req_prio)
  );

  irq_nest #(.N(N), .PW(PW)) u_nest (
    .clk(clk), .rst(rst),
    .push(ack_do), .push_id(req_id), .push_prio(req_prio),
    .pop(eoi_do), .depth(nest_depth),
    .top_valid(run_valid), .top_id(top_id), .top_prio(run_prio)
  );

  // strict preemption against the running level
  assign cpu_req  = found && (!run_valid || (req_prio < run_prio));
  assign eoi_do   = eoi && run_valid;
  assign ack_do   = ack && cpu_req && !eoi;
  assign take_vec = ack_do ? (N'(1) << req_id) : '0;
  assign ret_vec  = eoi_do ? (N'(1) << top_id) : '0;

  always_ff @(posedge clk) begin
    if (rst)                    eoi_err <= 1'b0;
    else if (eoi && !run_valid) eoi_err <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N   = 8,
  parameter int PW  = 3,
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int DW  = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           ack,
  input logic           eoi,
  input logic [N-1:0]   cfg_enable,
  input logic           cpu_req,
  input logic [IDW-1:0] req_id,
  input logic [PW-1:0]  req_prio,
  input logic           run_valid,
  input logic [PW-1:0]  run_prio,
  input logic [DW-1:0]  nest_depth,
  input logic [N-1:0]   active,
  input logic           eoi_err
);
  assert_mask_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> cfg_enable[req_id]);

  assert_strict_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && run_valid) |-> (req_prio < run_prio));

  assert_enter_R5: assert property (@(posedge clk) disable iff (rst)
    (ack && cpu_req && !eoi) |=> (active[$past(req_id)] && nest_depth == $past(nest_depth) + 1'b1));

  assert_unwind_R9: assert property (@(posedge clk) disable iff (rst)
    (eoi && run_valid) |=> (nest_depth == $past(nest_depth) - 1'b1));

  assert_err_set_R10: assert property (@(posedge clk) disable iff (rst)
    (eoi && !run_valid) |=> (eoi_err && nest_depth == '0));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    eoi_err |=> eoi_err);

  assert_collide_R11: assert property (@(posedge clk) disable iff (rst)
    (ack && eoi) |=> (nest_depth <= $past(nest_depth)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .eoi(eoi), .cfg_enable(cfg_enable),
  .cpu_req(cpu_req), .req_id(req_id), .req_prio(req_prio),
  .run_valid(run_valid), .run_prio(run_prio), .nest_depth(nest_depth),
  .active(active), .eoi_err(eoi_err)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int N = 8;
  localparam int PW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_in = '0, cfg_level, cfg_enable = '1;
  logic [N*PW-1:0] cfg_prio;
  logic [N-1:0] sw_set_pend = '0, sw_clr_pend = '0;
  logic ack = 1'b0, eoi = 1'b0;
  logic cpu_req, run_valid, eoi_err;
  logic [2:0] req_id;
  logic [PW-1:0] req_prio, run_prio;
  logic [3:0] nest_depth;
  logic [N-1:0] pending, active;

  int prio_b [N];
  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  bit m_pend [N];
  bit m_act  [N];
  bit m_lin  [N];
  int stk_id [N];
  int stk_pr [N];
  int sp = 0;
  bit m_err = 0;

  always #2 clk = ~clk;

  assign cfg_level = 8'h0F;  // lines 0..3 level, 4..7 pulse
  always_comb for (int i = 0; i < N; i++) cfg_prio[i*PW +: PW] = PW'(prio_b[i]);

  irq_prio_ctrl #(.N(N), .PW(PW)) u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_level(cfg_level),
    .cfg_enable(cfg_enable), .cfg_prio(cfg_prio),
    .sw_set_pend(sw_set_pend), .sw_clr_pend(sw_clr_pend),
    .ack(ack), .eoi(eoi), .cpu_req(cpu_req), .req_id(req_id),
    .req_prio(req_prio), .run_valid(run_valid), .run_prio(run_prio),
    .nest_depth(nest_depth), .pending(pending), .active(active),
    .eoi_err(eoi_err)
  );

  function automatic bit is_lvl(int k); return k < 4; endfunction

  function automatic void m_sel(output bit f, output int id, output int pr);
    f = 0; id = 0; pr = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && cfg_enable[i] && (!f || prio_b[i] < pr)) begin
        f = 1; id = i; pr = prio_b[i];
      end
  endfunction

  function automatic bit m_req(output int id, output int pr);
    bit f;
    m_sel(f, id, pr);
    return f && (sp == 0 || pr < stk_pr[sp-1]);
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    int id, pr, pv, av;
    bit r;
    r = m_req(id, pr);
    pv = 0; av = 0;
    for (int i = 0; i < N; i++) begin pv |= int'(m_pend[i]) << i; av |= int'(m_act[i]) << i; end
    chk(tag, "cpu_req", int'(cpu_req), int'(r));
    if (r) begin
      chk(tag, "req_id", int'(req_id), id);
      chk(tag, "req_prio", int'(req_prio), pr);
    end
    chk(tag, "pending", int'(pending), pv);
    chk(tag, "active", int'(active), av);
    chk(tag, "nest_depth", int'(nest_depth), sp);
    chk(tag, "run_valid", int'(run_valid), int'(sp != 0));
    if (sp != 0) chk(tag, "run_prio", int'(run_prio), stk_pr[sp-1]);
    chk(tag, "eoi_err", int'(eoi_err), int'(m_err));
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op_pulse(int k);
    irq_in[k] = 1'b1; @(negedge clk); irq_in[k] = 1'b0;
    m_pend[k] = 1;
    settle();
  endtask

  task automatic op_level(int k, bit v);
    irq_in[k] = v; m_lin[k] = v;
    if (v && !m_act[k]) m_pend[k] = 1;
    settle();
  endtask

  task automatic op_swset(int k);
    sw_set_pend[k] = 1'b1; @(negedge clk); sw_set_pend[k] = 1'b0;
    m_pend[k] = 1;
    settle();
  endtask

  task automatic op_swclr(int k);
    sw_clr_pend[k] = 1'b1; @(negedge clk); sw_clr_pend[k] = 1'b0;
    m_pend[k] = is_lvl(k) && m_lin[k] && !m_act[k];
    settle();
  endtask

  function automatic void m_eoi();
    if (sp == 0) m_err = 1;
    else begin
      sp--;
      m_act[stk_id[sp]] = 0;
      if (is_lvl(stk_id[sp]) && m_lin[stk_id[sp]]) m_pend[stk_id[sp]] = 1;
    end
  endfunction

  task automatic op_ack();
    int id, pr;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    if (m_req(id, pr)) begin
      m_pend[id] = 0; m_act[id] = 1;
      stk_id[sp] = id; stk_pr[sp] = pr; sp++;
    end
    settle();
  endtask

  task automatic op_eoi();
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    m_eoi();
    settle();
  endtask

  task automatic op_both();
    ack = 1'b1; eoi = 1'b1; @(negedge clk); ack = 1'b0; eoi = 1'b0;
    m_eoi();
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin prio_b[i] = 4; m_pend[i] = 0; m_act[i] = 0; m_lin[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    check_all("R1");

    op_eoi();                 check_all("R10");  // return with nothing running
    chk("R10", "sticky eoi_err", int'(eoi_err), 1);

    // mask, tie and strict preemption
    prio_b[5] = 2; prio_b[6] = 2; prio_b[1] = 1; prio_b[0] = 0;
    cfg_enable = 8'h7F;
    op_pulse(7);              check_all("R2");   // masked line: pending only
    chk("R2", "masked cpu_req", int'(cpu_req), 0);
    op_pulse(6); op_pulse(5); check_all("R3");   // tie -> lowest index 5
    chk("R3", "tie req_id", int'(req_id), 5);
    op_ack();                 check_all("R5");
    chk("R5", "run_prio", int'(run_prio), 2);
    op_ack();                 check_all("R5");   // ack with no request: no effect
    op_swset(1);              check_all("R4");   // prio 1 preempts prio 2
    chk("R4", "preempt req", int'(cpu_req), 1);
    op_ack();                 check_all("R4");   // 6 at equal prio 2 must wait
    chk("R4", "depth 2", int'(nest_depth), 2);
    op_eoi();                 check_all("R9");
    chk("R9", "run_prio back", int'(run_prio), 2);
    op_pulse(5);              check_all("R7");   // active and pending
    chk("R7", "act+pend", int'(pending[5] & active[5]), 1);
    op_eoi();                 check_all("R7");   // re-presented
    chk("R7", "re-presented id", int'(req_id), 5);
    op_ack(); op_eoi();       check_all("R7");

    // level line behaviour
    op_level(0, 1);           check_all("R6");
    op_ack();                 check_all("R6");   // active, held input does not re-pend
    op_eoi();                 check_all("R6");   // still asserted -> pending
    chk("R6", "level re-pend", int'(pending[0]), 1);
    op_ack();
    op_level(0, 0);
    op_eoi();                 check_all("R6");
    chk("R6", "level idle", int'(pending[0]), 0);
    op_level(0, 1);
    op_swclr(0);              check_all("R8");   // re-pends
    chk("R8", "clr no effect", int'(pending[0]), 1);
    op_level(0, 0);
    op_swclr(0);              check_all("R8");

    // ack and eoi in the same cycle
    op_swset(4);              // prio 4
    op_ack();
    op_swset(1);              // prio 1 waiting, would preempt
    op_both();                check_all("R11");
    chk("R11", "depth after collide", int'(nest_depth), 0);
    chk("R11", "waiting line not entered", int'(active[1]), 0);
    op_ack(); op_eoi();

    // constrained random with fixed seed
    for (int i = 0; i < N; i++) prio_b[i] = $urandom_range(0, 7);
    cfg_enable = 8'hFF ^ (8'h1 << $urandom_range(0, 7));
    for (int s = 0; s < 300; s++) begin
      int r, k, id, pr;
      r = $urandom_range(0, 9);
      if (r <= 2 && m_req(id, pr)) op_ack();
      else if (r <= 4 && sp > 0) op_eoi();
      else if (r == 5) op_pulse($urandom_range(4, 7));
      else if (r == 6) begin k = $urandom_range(0, 3); op_level(k, !m_lin[k]); end
      else if (r == 7) op_swset($urandom_range(0, 7));
      else if (r == 8) op_swclr($urandom_range(0, 7));
      else if (m_req(id, pr)) op_both();
      else op_eoi();
      check_all("R3 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule